// File: doc/BRIEF.md
# Serial Frame Bit Counter with Transmit Interrupts

This block sets the length of each frame of a byte-oriented serial link and follows the frame bit by bit. The link runs in one of two modes. In two-wire bus mode each frame carries an acknowledge bit after the data. In clocked synchronous mode the frame is data only. Software writes a 3-bit length code. The block turns that code into a frame length for the active mode. It counts the frame down on rising edges of the sampled serial clock. While a frame runs, the code output shows the bits that are still to go.

The block also produces two interrupt requests. The transmit-empty request follows the data-empty flag, gated by its enable. The transmit-end request comes from a sticky flag. The flag is set on the rising edge of the ninth serial clock of a frame while the data-empty flag is 1. The request is gated by its own enable. Writes to the code field that break the loading rules are dropped without any effect.

Top module: `serial_bitcnt`

## Requirements
- R1: In two-wire mode (`two_wire_i`=1), a stored code of 0 gives a frame of 9 rising serial clock edges, and a code c from 1 to 7 gives c+1 edges.
- R2: In synchronous mode (`two_wire_i`=0), a stored code of 0 gives a frame of 8 edges, and a code c from 1 to 7 gives c edges. The code in force is the one stored when the first edge arrives.
- R3: Between frames, `cnt_code_o` shows the stored code. After k edges of a frame of length L, it shows the remaining count r=L-k. In two-wire mode r reads as r-1 for r from 2 to 8, and as 0 for r=1. In synchronous mode r reads as r for r from 1 to 7.
- R4: The final edge of a frame sets `frame_done_o` high for exactly one clock cycle. From that same cycle on, `cnt_code_o` reads 0, and the stored code is 0.
- R5: A write of a non-zero code while `sclk_i` is high has no effect.
- R6: A write to the code field while a frame is in progress has no effect.
- R7: In synchronous mode every write to the code field has no effect.
- R8: `irq_txe_o` is 1 exactly when `data_empty_i` is 1 and the transmit-empty enable is 1.
- R9: `tend_o` is set by the ninth rising edge of a frame if `data_empty_i` is 1 at that edge. It is not set otherwise, and writing 1 to it does not set it.
- R10: `irq_tend_o` equals `tend_o` AND the transmit-end enable. It is withdrawn by writing 0 to the flag or 0 to the enable.
- R11: After reset, both enables, `tend_o`, the stored code and both interrupt outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_wr_i | input | 1 | Write strobe for the code field |
| cnt_code_i | input | 3 | Code value to write |
| ctl_wr_i | input | 1 | Write strobe for the interrupt control fields |
| ctl_txe_en_i | input | 1 | Transmit-empty enable value to write |
| ctl_tend_en_i | input | 1 | Transmit-end enable value to write |
| ctl_tend_i | input | 1 | Transmit-end flag value to write (0 clears it, 1 has no effect) |
| sclk_i | input | 1 | Sampled serial clock level |
| two_wire_i | input | 1 | Mode select: 1 two-wire bus, 0 synchronous |
| data_empty_i | input | 1 | Transmit data empty flag |
| cnt_code_o | output | 3 | Stored code, or the remaining count during a frame |
| frame_done_o | output | 1 | One-cycle pulse after the final edge of a frame |
| tend_o | output | 1 | Sticky transmit-end flag |
| irq_txe_o | output | 1 | Transmit-empty interrupt request |
| irq_tend_o | output | 1 | Transmit-end interrupt request |

## Verification
A rising edge of `sclk_i` is seen at the first clock edge where the input is high. The count, `frame_done_o` and `tend_o` then change at that same clock edge, so the bench raises `sclk_i` at a falling clock edge and checks these outputs at the next falling edge. A write also takes effect at the first rising clock edge, and the bench checks the code one falling edge after the strobe. `frame_done_o` is checked high in that slot and low again one clock later. `irq_txe_o` is combinational in its inputs, and `irq_tend_o` follows its flag and enable registers with no further delay. The bench checks both half a cycle after each change of input or register.

// File: rtl/serial_bitcnt_pkg.sv
package serial_bitcnt_pkg;
  typedef enum logic {
    MODE_SYNC     = 1'b0,
    MODE_TWO_WIRE = 1'b1
  } link_mode_e;

  typedef struct packed {
    logic txe_en;
    logic tend_en;
    logic tend;
  } irq_state_t;
endpackage

// File: rtl/serial_bitcnt_edge.sv
module serial_bitcnt_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  output logic rise_o
);
  logic sclk_q;

  // reset high so a clock already high at reset release is not an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b1;
    else         sclk_q <= sclk_i;
  end

  assign rise_o = sclk_i & ~sclk_q;
endmodule

// File: rtl/serial_bitcnt_counter.sv
module serial_bitcnt_counter
  import serial_bitcnt_pkg::*;
#(
  parameter int unsigned CODE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              sclk_i,
  input  link_mode_e        mode_i,
  input  logic              wr_i,
  input  logic [CODE_W-1:0] wr_code_i,
  output logic [CODE_W-1:0] code_o,
  output logic              done_o,
  output logic              active_o,
  output logic              tend_edge_o
);
  localparam int unsigned DATA_BITS = 1 << CODE_W;
  localparam int unsigned FRAME_MAX = DATA_BITS + 1;
  localparam int unsigned CNT_W     = $clog2(FRAME_MAX + 1);
  localparam int unsigned TEND_EDGE = FRAME_MAX;

  typedef logic [CNT_W-1:0] cnt_t;

  function automatic cnt_t frame_len(input logic [CODE_W-1:0] c, input link_mode_e m);
    cnt_t cv;
    cv = cnt_t'(c);
    if (c == '0) return (m == MODE_TWO_WIRE) ? cnt_t'(FRAME_MAX) : cnt_t'(DATA_BITS);
    return (m == MODE_TWO_WIRE) ? cv + cnt_t'(1) : cv;
  endfunction

  function automatic logic [CODE_W-1:0] rem_code(input cnt_t r, input link_mode_e m);
    if (m == MODE_TWO_WIRE) begin
      if (r <= cnt_t'(1) || r >= cnt_t'(FRAME_MAX)) return '0;
      return CODE_W'(r - cnt_t'(1));
    end
    if (r >= cnt_t'(DATA_BITS)) return '0;
    return CODE_W'(r);
  endfunction

  logic [CODE_W-1:0] code_q;
  logic              active_q;
  logic              done_q;
  cnt_t              rem_q, rem_n;
  cnt_t              edges_q, edges_n;
  logic              load_ok;

  always_comb begin
    if (active_q) begin
      rem_n   = rem_q - cnt_t'(1);
      edges_n = edges_q + cnt_t'(1);
    end else begin
      rem_n   = frame_len(code_q, mode_i) - cnt_t'(1);
      edges_n = cnt_t'(1);
    end
  end

  // loads only between frames, in two-wire mode, non-zero only with clock low
  assign load_ok = wr_i && !active_q && !rise_i && (mode_i == MODE_TWO_WIRE) &&
                   ((wr_code_i == '0) || !sclk_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q   <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
      rem_q    <= '0;
      edges_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (rise_i) begin
        rem_q   <= rem_n;
        edges_q <= edges_n;
        if (rem_n == '0) begin
          active_q <= 1'b0;
          code_q   <= '0;
          done_q   <= 1'b1;
        end else begin
          active_q <= 1'b1;
        end
      end else if (load_ok) begin
        code_q <= wr_code_i;
      end
    end
  end

  assign code_o      = active_q ? rem_code(rem_q, mode_i) : code_q;
  assign done_o      = done_q;
  assign active_o    = active_q;
  assign tend_edge_o = rise_i && (edges_n == cnt_t'(TEND_EDGE));
endmodule

// File: rtl/serial_bitcnt_irq.sv
module serial_bitcnt_irq
  import serial_bitcnt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic txe_en_i,
  input  logic tend_en_i,
  input  logic tend_i,
  input  logic tend_edge_i,
  input  logic data_empty_i,
  output logic tend_o,
  output logic irq_txe_o,
  output logic irq_tend_o
);
  irq_state_t st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0;
    end else begin
      if (wr_i) begin
        st_q.txe_en  <= txe_en_i;
        st_q.tend_en <= tend_en_i;
      end
      // set beats a clearing write in the same cycle
      if (tend_edge_i && data_empty_i) st_q.tend <= 1'b1;
      else if (wr_i && !tend_i)        st_q.tend <= 1'b0;
    end
  end

  assign tend_o     = st_q.tend;
  assign irq_txe_o  = data_empty_i & st_q.txe_en;
  assign irq_tend_o = st_q.tend & st_q.tend_en;
endmodule

// File: rtl/serial_bitcnt.sv
module serial_bitcnt
  import serial_bitcnt_pkg::*;
#(
  parameter int unsigned CODE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnt_wr_i,
  input  logic [CODE_W-1:0] cnt_code_i,
  input  logic              ctl_wr_i,
  input  logic              ctl_txe_en_i,
  input  logic              ctl_tend_en_i,
  input  logic              ctl_tend_i,
  input  logic              sclk_i,
  input  logic              two_wire_i,
  input  logic              data_empty_i,
  output logic [CODE_W-1:0] cnt_code_o,
  output logic              frame_done_o,
  output logic              tend_o,
  output logic              irq_txe_o,
  output logic              irq_tend_o
);
  logic       rise;
  logic       active;
  logic       tend_edge;
  link_mode_e mode;

  assign mode = two_wire_i ? MODE_TWO_WIRE : MODE_SYNC;

  serial_bitcnt_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sclk_i (sclk_i),
    .rise_o (rise)
  );

  serial_bitcnt_counter #(.CODE_W(CODE_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rise_i      (rise),
    .sclk_i      (sclk_i),
    .mode_i      (mode),
    .wr_i        (cnt_wr_i),
    .wr_code_i   (cnt_code_i),
    .code_o      (cnt_code_o),
    .done_o      (frame_done_o),
    .active_o    (active),
    .tend_edge_o (tend_edge)
  );

  serial_bitcnt_irq u_irq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (ctl_wr_i),
    .txe_en_i     (ctl_txe_en_i),
    .tend_en_i    (ctl_tend_en_i),
    .tend_i       (ctl_tend_i),
    .tend_edge_i  (tend_edge),
    .data_empty_i (data_empty_i),
    .tend_o       (tend_o),
    .irq_txe_o    (irq_txe_o),
    .irq_tend_o   (irq_tend_o)
  );
endmodule

// File: rtl/serial_bitcnt_chk.sv
module serial_bitcnt_chk #(
  parameter int unsigned CODE_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cnt_wr_i,
  input logic [CODE_W-1:0] cnt_code_i,
  input logic              sclk_i,
  input logic              two_wire_i,
  input logic              data_empty_i,
  input logic [CODE_W-1:0] cnt_code_o,
  input logic              frame_done_o,
  input logic              tend_o,
  input logic              irq_txe_o,
  input logic              irq_tend_o,
  input logic              active_i
);
  logic sclk_d;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_d <= 1'b1;
    else         sclk_d <= sclk_i;
  end

  p_done_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o);

  p_done_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> (cnt_code_o == '0) && !active_i);

  p_high_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (two_wire_i && cnt_wr_i && sclk_i && sclk_d && (cnt_code_i != '0) && !active_i)
    |=> (cnt_code_o == $past(cnt_code_o)));

  p_sync_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!two_wire_i && cnt_wr_i && !sclk_i && !active_i)
    |=> (cnt_code_o == $past(cnt_code_o)));

  p_txe_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_txe_o |-> data_empty_i);

  p_tend_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tend_o) |-> $past(data_empty_i) && $past(sclk_i) && !$past(sclk_d));

  p_tend_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_tend_o |-> tend_o);
endmodule

bind serial_bitcnt serial_bitcnt_chk #(.CODE_W(CODE_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cnt_wr_i     (cnt_wr_i),
  .cnt_code_i   (cnt_code_i),
  .sclk_i       (sclk_i),
  .two_wire_i   (two_wire_i),
  .data_empty_i (data_empty_i),
  .cnt_code_o   (cnt_code_o),
  .frame_done_o (frame_done_o),
  .tend_o       (tend_o),
  .irq_txe_o    (irq_txe_o),
  .irq_tend_o   (irq_tend_o),
  .active_i     (active)
);

// File: tb/serial_bitcnt_test.sv
`timescale 1ns/1ps
module serial_bitcnt_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cnt_wr_i = 1'b0;
  logic [2:0] cnt_code_i = '0;
  logic       ctl_wr_i = 1'b0;
  logic       ctl_txe_en_i = 1'b0;
  logic       ctl_tend_en_i = 1'b0;
  logic       ctl_tend_i = 1'b0;
  logic       sclk_i = 1'b1;
  logic       two_wire_i = 1'b1;
  logic       data_empty_i = 1'b0;
  logic [2:0] cnt_code_o;
  logic       frame_done_o, tend_o, irq_txe_o, irq_tend_o;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  always #2 clk_i = ~clk_i;

  serial_bitcnt uut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_code(input logic [2:0] c);
    @(negedge clk_i); cnt_wr_i = 1'b1; cnt_code_i = c;
    @(negedge clk_i); cnt_wr_i = 1'b0;
  endtask

  task automatic wr_ctl(input logic txe, input logic te, input logic fl);
    @(negedge clk_i); ctl_wr_i = 1'b1; ctl_txe_en_i = txe; ctl_tend_en_i = te; ctl_tend_i = fl;
    @(negedge clk_i); ctl_wr_i = 1'b0;
  endtask

  function automatic int exp_len(input int c, input bit tw);
    if (c == 0) return tw ? 9 : 8;
    return tw ? c + 1 : c;
  endfunction

  function automatic int exp_code(input int r, input bit tw);
    if (tw) return (r <= 1 || r >= 9) ? 0 : r - 1;
    return (r >= 8) ? 0 : r;
  endfunction

  // sclk_i must be low on entry; leaves it low
  task automatic run_frame(input int c, input bit tw);
    int len;
    len = exp_len(c, tw);
    two_wire_i = 1'b1;
    wr_code(3'(c));
    two_wire_i = tw;
    if (!tw) begin
      wr_code(3'(c ^ 7));
      check(cnt_code_o == 3'(c), "R7 sync write ignored", cnt_code_o, c);
    end
    check(cnt_code_o == 3'(c), "R3 idle readback", cnt_code_o, c);
    for (int k = 1; k <= len; k++) begin
      @(negedge clk_i); sclk_i = 1'b1;
      @(negedge clk_i);
      if (k < len) begin
        check(cnt_code_o == 3'(exp_code(len - k, tw)), tw ? "R1 R3 remaining" : "R2 R3 remaining",
              cnt_code_o, exp_code(len - k, tw));
        check(frame_done_o == 1'b0, "R4 no early done", frame_done_o, 0);
      end else begin
        check(frame_done_o == 1'b1, tw ? "R1 R4 done at length" : "R2 R4 done at length",
              frame_done_o, 1);
        check(cnt_code_o == 3'd0, "R4 code cleared", cnt_code_o, 0);
      end
      sclk_i = 1'b0;
      @(negedge clk_i);
      if (k == len) check(frame_done_o == 1'b0, "R4 single pulse", frame_done_o, 0);
    end
    two_wire_i = 1'b1;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc == 100000) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R11 reset state
    check(cnt_code_o == 3'd0, "R11 code", cnt_code_o, 0);
    check(tend_o == 1'b0, "R11 tend", tend_o, 0);
    data_empty_i = 1'b1;
    #0.5;
    check(irq_txe_o == 1'b0, "R11 txe irq", irq_txe_o, 0);
    check(irq_tend_o == 1'b0, "R11 tend irq", irq_tend_o, 0);
    data_empty_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R5: non-zero write with serial clock high (no edge) ignored
    wr_code(3'd5);
    check(cnt_code_o == 3'd0, "R5 high write ignored", cnt_code_o, 0);
    sclk_i = 1'b0;
    wr_code(3'd3);
    check(cnt_code_o == 3'd3, "R5 low write accepted", cnt_code_o, 3);

    // R6: write during frame ignored (frame of 4 edges)
    @(negedge clk_i); sclk_i = 1'b1;
    @(negedge clk_i); sclk_i = 1'b0;
    check(cnt_code_o == 3'd2, "R3 remaining after one edge", cnt_code_o, 2);
    wr_code(3'd6);
    check(cnt_code_o == 3'd2, "R6 mid-frame write ignored", cnt_code_o, 2);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i); sclk_i = 1'b1;
      @(negedge clk_i);
      if (k < 2) sclk_i = 1'b0;
    end
    check(cnt_code_o == 3'd0, "R4 end of frame", cnt_code_o, 0);
    wr_code(3'd6);
    check(cnt_code_o == 3'd0, "R5 high write after frame ignored", cnt_code_o, 0);
    sclk_i = 1'b0;
    @(negedge clk_i);

    // sweep modes and codes, R9 expectations per frame
    for (int m = 1; m >= 0; m--) begin
      for (int c = 0; c < 8; c++) begin
        wr_ctl(1'b0, 1'b0, 1'b0);
        data_empty_i = 1'b1;
        run_frame(c, m[0]);
        check(tend_o == ((m == 1) && (c == 0)), "R9 tend after frame", tend_o,
              (m == 1) && (c == 0));
      end
    end

    // R9: ninth edge with data_empty low does not set
    wr_ctl(1'b0, 1'b0, 1'b0);
    data_empty_i = 1'b0;
    run_frame(0, 1'b1);
    check(tend_o == 1'b0, "R9 no set when not empty", tend_o, 0);
    wr_ctl(1'b0, 1'b0, 1'b1);
    check(tend_o == 1'b0, "R9 write 1 does not set", tend_o, 0);

    // R8: transmit-empty gating, all four combinations
    for (int e = 0; e < 2; e++) begin
      for (int d = 0; d < 2; d++) begin
        wr_ctl(e[0], 1'b0, 1'b1);
        data_empty_i = d[0];
        #0.5;
        check(irq_txe_o == (e[0] & d[0]), "R8 txe gating", irq_txe_o, e & d);
      end
    end

    // R10: transmit-end request and its removal
    data_empty_i = 1'b1;
    run_frame(0, 1'b1);
    check(tend_o == 1'b1, "R9 set on ninth edge", tend_o, 1);
    check(irq_tend_o == 1'b0, "R10 disabled", irq_tend_o, 0);
    wr_ctl(1'b0, 1'b1, 1'b1);
    check(irq_tend_o == 1'b1, "R10 request", irq_tend_o, 1);
    wr_ctl(1'b0, 1'b0, 1'b1);
    check(irq_tend_o == 1'b0, "R10 removed by enable", irq_tend_o, 0);
    check(tend_o == 1'b1, "R10 flag kept", tend_o, 1);
    wr_ctl(1'b0, 1'b1, 1'b1);
    check(irq_tend_o == 1'b1, "R10 request again", irq_tend_o, 1);
    wr_ctl(1'b0, 1'b1, 1'b0);
    check(irq_tend_o == 1'b0, "R10 removed by flag clear", irq_tend_o, 0);
    check(tend_o == 1'b0, "R10 flag cleared", tend_o, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule